// File: doc/BRIEF.md
# DDR SDRAM Command Bus Monitor

This block sits beside a DDR SDRAM command bus and samples the chip-select, row strobe, column strobe, write enable, clock enable, bank and address pins on every rising clock edge. Each sampled cycle is turned into exactly one command code. The fields that command carries are split out: bank, row, column, auto-precharge request, all-bank precharge, mode-register target and opcode. All of these appear one clock later on registered outputs.

The monitor also keeps a small amount of protocol state. This is the programmed burst length, whether the device sits in self refresh, and the kind of data burst currently in flight. With this state it flags command sequences the memory does not allow. It also reports the data-mask lanes for every clock of a write burst, so a scoreboard can tell which bytes were really written. Timing-parameter checks and data capture belong to other blocks.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: While reset is high, and in the first cycle after it, every output is zero (command code 0, no error, no write beat). The burst length after reset is 2 clock cycles per burst.
- R2: A cycle with chip-select high, or with pins {ras_n,cas_n,we_n} = 111, reports code 0 (no operation). With chip-select low the {ras_n,cas_n,we_n} encodings 011, 101, 100, 110, 010 and 000 report codes 1 (activate), 2 (read), 3 (write), 4 (burst stop), 5 (precharge) and 8 (mode load). Each code appears on cmd_o one clock after the sampling edge.
- R3: For a read or a write, bank_o carries the bank pins, col_o carries addr[9:0] and ap_o carries addr[10].
- R4: For an activate, bank_o carries the bank pins and row_o carries the full address. For any other command, row_o is zero.
- R5: For a precharge with addr[10] high, all_bank_o is 1 and bank_o is 0. With addr[10] low, all_bank_o is 0 and bank_o names the bank.
- R6: For a mode load, opcode_o carries the full address. Bank pins 00 select the base register and bank pins 10 select the extended one (ext_mr_o = 1). Bank pins 01 or 11 set err_cause_o bit 2. Only a load to the base register with addr[2:0] equal to 1, 2 or 3 changes the burst, to 1, 2 or 4 clock cycles.
- R7: Encoding 001 reports code 6 (auto refresh) with clock enable high and code 7 (self-refresh entry) with it low. From entry on, every cycle reports code 0 with no error and no effect. This includes the first cycle with clock enable high, and normal decoding resumes after that cycle.
- R8: Outside self refresh, a command other than no-operation or self-refresh entry that is sampled with clock enable low is still classified. It sets err_cause_o bit 0 and changes no state.
- R9: A burst stop is legal only while a read burst without auto precharge is active. A legal stop ends that burst. In every other case it sets err_cause_o bit 1 and changes nothing.
- R10: A read or write starts a burst that stays active for the programmed number of following cycles. A new read or write restarts it. A precharge to the burst's bank, or an all-bank precharge, ends it, and a precharge to another bank does not.
- R11: In each cycle of an active write burst, wbeat_o is 1 and wmask_o copies the dm pins (1 = lane masked, 0 = lane written). Otherwise both are zero.
- R12: err_o is 1 exactly when some bit of err_cause_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BA_W | Bank pins |
| addr | input | ADDR_W | Address pins |
| dm | input | DM_W | Data-mask lanes of the current write beat |
| cmd_o | output | 4 | Command code of the sampled cycle |
| bank_o | output | BA_W | Bank of the command |
| row_o | output | ADDR_W | Row of an activate |
| col_o | output | COL_W | Column of a read or write |
| ap_o | output | 1 | Auto precharge requested |
| all_bank_o | output | 1 | Precharge targets all banks |
| ext_mr_o | output | 1 | Mode load targets the extended register |
| opcode_o | output | ADDR_W | Mode load opcode |
| err_o | output | 1 | Illegal command seen |
| err_cause_o | output | 3 | bit0 clock enable low, bit1 bad burst stop, bit2 bad register select |
| wbeat_o | output | 1 | A write burst beat occupied this cycle |
| wmask_o | output | DM_W | Masked lanes of this write beat |

## Verification
A write beat report and a command decode can land in the same output cycle. This happens when a burst stop, a new read or a precharge is issued while a write burst is still running. The bench issues a burst stop on the clock right after a write and expects three things on the same clock: code 4, error bit 1, and wbeat_o high. On the following clock it expects the beat to continue, which shows that the rejected stop left the burst alone. The exhaustive pin sweeps run back to back without idle cycles, so classification and burst-state updates also meet in the same cycle there.

// File: rtl/ddrmon_pkg.sv
package ddrmon_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_BST  = 4'd4,
    CMD_PRE  = 4'd5,
    CMD_AREF = 4'd6,
    CMD_SREF = 4'd7,
    CMD_LMR  = 4'd8
  } cmd_e;

  typedef struct packed {
    logic mr_bad;
    logic bst_bad;
    logic cke_bad;
  } err_t;

endpackage

// File: rtl/ddrmon_cmd_decode.sv
module ddrmon_cmd_decode
  import ddrmon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  input  logic in_sr,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_NOP;
    if (!in_sr && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_BST;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = cke ? CMD_AREF : CMD_SREF;
        3'b000:  cmd = CMD_LMR;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddrmon_mode_reg.sv
module ddrmon_mode_reg #(
  parameter int FIELD_W    = 3,
  parameter int MAX_CODE   = 3,
  parameter int RESET_CODE = 2,
  parameter int CNT_W      = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FIELD_W-1:0] code,
  output logic [CNT_W-1:0]   bl_cyc
);

  logic code_ok;
  assign code_ok = (code >= FIELD_W'(1)) && (code <= FIELD_W'(MAX_CODE));

  always_ff @(posedge clk) begin
    if (rst) begin
      bl_cyc <= CNT_W'(1) << (RESET_CODE - 1);
    end else if (load && code_ok) begin
      bl_cyc <= CNT_W'(1) << (code - FIELD_W'(1));
    end
  end

endmodule

// File: rtl/ddrmon_burst_track.sv
module ddrmon_burst_track #(
  parameter int BA_W  = 2,
  parameter int CNT_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            start_wr,
  input  logic            start_ap,
  input  logic [BA_W-1:0] start_bank,
  input  logic            cut,
  input  logic            pre,
  input  logic            pre_all,
  input  logic [BA_W-1:0] pre_bank,
  input  logic [CNT_W-1:0] bl_cyc,
  output logic            rd_plain,
  output logic            wr_beat
);

  logic [CNT_W-1:0] left_q;
  logic             wr_q;
  logic             ap_q;
  logic [BA_W-1:0]  bank_q;
  logic             active;
  logic             pre_hit;

  assign active   = (left_q != '0);
  assign pre_hit  = pre && (pre_all || (pre_bank == bank_q));
  assign rd_plain = active && !wr_q && !ap_q;
  assign wr_beat  = active && wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      wr_q   <= 1'b0;
      ap_q   <= 1'b0;
      bank_q <= '0;
    end else if (start) begin
      left_q <= bl_cyc;
      wr_q   <= start_wr;
      ap_q   <= start_ap;
      bank_q <= start_bank;
    end else if (cut || pre_hit) begin
      left_q <= '0;
    end else if (active) begin
      left_q <= left_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddrmon_pkg::*;
#(
  parameter int BA_W          = 2,
  parameter int ADDR_W        = 13,
  parameter int COL_W         = 10,
  parameter int AP_BIT        = 10,
  parameter int DM_W          = 2,
  parameter int BL_FIELD_W    = 3,
  parameter int MAX_BL_CODE   = 3,
  parameter int RESET_BL_CODE = 2,
  parameter int EXT_MR_SEL    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              cke,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DM_W-1:0]   dm,
  output logic [3:0]        cmd_o,
  output logic [BA_W-1:0]   bank_o,
  output logic [ADDR_W-1:0] row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              ap_o,
  output logic              all_bank_o,
  output logic              ext_mr_o,
  output logic [ADDR_W-1:0] opcode_o,
  output logic              err_o,
  output logic [2:0]        err_cause_o,
  output logic              wbeat_o,
  output logic [DM_W-1:0]   wmask_o
);

  localparam int MAX_CYC = 1 << (MAX_BL_CODE - 1);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  cmd_e             cmd;
  logic             in_sr;
  logic             live;
  logic             is_rw;
  logic             mr_base;
  logic             mr_ext;
  logic             rd_plain;
  logic             wr_beat;
  logic [CNT_W-1:0] bl_cyc;
  err_t             err_n;
  logic [DM_W-1:0]  mask_n;

  ddrmon_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cke   (cke),
    .in_sr (in_sr),
    .cmd   (cmd)
  );

  assign live    = !in_sr && cke;
  assign is_rw   = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign mr_base = (ba == '0);
  assign mr_ext  = (ba == BA_W'(EXT_MR_SEL));

  ddrmon_mode_reg #(
    .FIELD_W    (BL_FIELD_W),
    .MAX_CODE   (MAX_BL_CODE),
    .RESET_CODE (RESET_BL_CODE),
    .CNT_W      (CNT_W)
  ) u_mode (
    .clk    (clk),
    .rst    (rst),
    .load   (live && (cmd == CMD_LMR) && mr_base),
    .code   (addr[BL_FIELD_W-1:0]),
    .bl_cyc (bl_cyc)
  );

  ddrmon_burst_track #(
    .BA_W  (BA_W),
    .CNT_W (CNT_W)
  ) u_burst (
    .clk        (clk),
    .rst        (rst),
    .start      (live && is_rw),
    .start_wr   (cmd == CMD_WR),
    .start_ap   (addr[AP_BIT]),
    .start_bank (ba),
    .cut        (live && (cmd == CMD_BST) && rd_plain),
    .pre        (live && (cmd == CMD_PRE)),
    .pre_all    (addr[AP_BIT]),
    .pre_bank   (ba),
    .bl_cyc     (bl_cyc),
    .rd_plain   (rd_plain),
    .wr_beat    (wr_beat)
  );

  // self-refresh residency: entered on the low-CKE refresh encoding,
  // left on the first sampled cycle with CKE high
  always_ff @(posedge clk) begin
    if (rst) begin
      in_sr <= 1'b0;
    end else if (in_sr) begin
      if (cke) in_sr <= 1'b0;
    end else if (cmd == CMD_SREF) begin
      in_sr <= 1'b1;
    end
  end

  always_comb begin
    err_n.cke_bad = !in_sr && !cke && (cmd != CMD_NOP) && (cmd != CMD_SREF);
    err_n.bst_bad = live && (cmd == CMD_BST) && !rd_plain;
    err_n.mr_bad  = live && (cmd == CMD_LMR) && !mr_base && !mr_ext;
  end

  for (genvar g = 0; g < DM_W; g++) begin : g_lane
    assign mask_n[g] = wr_beat & dm[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o       <= '0;
      bank_o      <= '0;
      row_o       <= '0;
      col_o       <= '0;
      ap_o        <= 1'b0;
      all_bank_o  <= 1'b0;
      ext_mr_o    <= 1'b0;
      opcode_o    <= '0;
      err_o       <= 1'b0;
      err_cause_o <= '0;
      wbeat_o     <= 1'b0;
      wmask_o     <= '0;
    end else begin
      cmd_o       <= 4'(cmd);
      bank_o      <= (cmd == CMD_ACT || is_rw ||
                      (cmd == CMD_PRE && !addr[AP_BIT])) ? ba : '0;
      row_o       <= (cmd == CMD_ACT) ? addr : '0;
      col_o       <= is_rw ? addr[COL_W-1:0] : '0;
      ap_o        <= is_rw && addr[AP_BIT];
      all_bank_o  <= (cmd == CMD_PRE) && addr[AP_BIT];
      ext_mr_o    <= (cmd == CMD_LMR) && mr_ext;
      opcode_o    <= (cmd == CMD_LMR) ? addr : '0;
      err_o       <= err_n.cke_bad || err_n.bst_bad || err_n.mr_bad;
      err_cause_o <= err_n;
      wbeat_o     <= wr_beat;
      wmask_o     <= mask_n;
    end
  end

endmodule

// File: rtl/ddrmon_chk.sv
module ddrmon_chk #(
  parameter int BA_W = 2,
  parameter int DM_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            cs_n,
  input logic            cke,
  input logic [3:0]      cmd_o,
  input logic [BA_W-1:0] bank_o,
  input logic            all_bank_o,
  input logic            err_o,
  input logic [2:0]      err_cause_o,
  input logic            wbeat_o,
  input logic [DM_W-1:0] wmask_o
);

  // R2
  desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n && cke) |=> (cmd_o == 4'd0 && !err_o));

  // R12
  err_sum_chk: assert property (@(posedge clk) disable iff (rst)
    err_o == (|err_cause_o));

  // R11
  idle_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !wbeat_o |-> (wmask_o == '0));

  // R5
  pre_all_chk: assert property (@(posedge clk) disable iff (rst)
    all_bank_o |-> (cmd_o == 4'd5 && bank_o == '0));

  // R9
  bst_in_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wbeat_o && cmd_o == 4'd4 && $past(cke)) |-> err_cause_o[1]);

  // R8
  err_not_idle_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (cmd_o != 4'd0));

endmodule

bind ddr_cmd_monitor ddrmon_chk #(
  .BA_W (BA_W),
  .DM_W (DM_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_n        (cs_n),
  .cke         (cke),
  .cmd_o       (cmd_o),
  .bank_o      (bank_o),
  .all_bank_o  (all_bank_o),
  .err_o       (err_o),
  .err_cause_o (err_cause_o),
  .wbeat_o     (wbeat_o),
  .wmask_o     (wmask_o)
);

// File: tb/ddr_cmd_monitor_test.sv
module ddr_cmd_monitor_test;

  localparam int CLK_P = 10;

  localparam logic [3:0] E_NOP = 4'b0111;
  localparam logic [3:0] E_ACT = 4'b0011;
  localparam logic [3:0] E_RD  = 4'b0101;
  localparam logic [3:0] E_WR  = 4'b0100;
  localparam logic [3:0] E_BST = 4'b0110;
  localparam logic [3:0] E_PRE = 4'b0010;
  localparam logic [3:0] E_REF = 4'b0001;
  localparam logic [3:0] E_LMR = 4'b0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [1:0]  dm = '0;

  logic [3:0]  cmd_o;
  logic [1:0]  bank_o;
  logic [12:0] row_o;
  logic [9:0]  col_o;
  logic        ap_o, all_bank_o, ext_mr_o;
  logic [12:0] opcode_o;
  logic        err_o;
  logic [2:0]  err_cause_o;
  logic        wbeat_o;
  logic [1:0]  wmask_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  ddr_cmd_monitor uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .ba(ba), .addr(addr), .dm(dm),
    .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o), .ap_o(ap_o),
    .all_bank_o(all_bank_o), .ext_mr_o(ext_mr_o), .opcode_o(opcode_o),
    .err_o(err_o), .err_cause_o(err_cause_o), .wbeat_o(wbeat_o), .wmask_o(wmask_o)
  );

  function automatic int cls(logic [3:0] c, logic k);
    if (c[3]) return 0;
    case (c[2:0])
      3'b011:  return 1;
      3'b101:  return 2;
      3'b100:  return 3;
      3'b110:  return 4;
      3'b010:  return 5;
      3'b001:  return k ? 6 : 7;
      3'b000:  return 8;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] c, logic k, logic [1:0] b, logic [12:0] a, logic [1:0] d);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = c;
    cke = k; ba = b; addr = a; dm = d;
    @(posedge clk);
    #1;
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) drive(E_NOP, 1'b1, 2'd0, 13'd0, 2'd0);
  endtask

  task automatic cause(string tag, int c);
    chk(tag, int'(err_cause_o), c);
    chk({tag, " R12 err"}, int'(err_o), (c != 0) ? 1 : 0);
  endtask

  task automatic beats(string tag, int n);
    for (int i = 0; i < n; i++) begin
      drive(E_NOP, 1'b1, 2'd0, 13'd0, 2'(i + 1));
      chk({tag, " beat"}, int'(wbeat_o), 1);
      chk({tag, " mask"}, int'(wmask_o), (i + 1) % 4);
    end
    drive(E_NOP, 1'b1, 2'd0, 13'd0, 2'd3);
    chk({tag, " after-burst beat"}, int'(wbeat_o), 0);
    chk({tag, " after-burst mask"}, int'(wmask_o), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [12:0] av [6] = '{13'h0000, 13'h1FFF, 13'h0A55, 13'h15AA, 13'h0400, 13'h03FF};

    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 cmd", int'(cmd_o), 0);
    chk("R1 err", int'(err_o), 0);
    chk("R1 beat", int'(wbeat_o), 0);
    chk("R1 fields", int'(row_o) + int'(col_o) + int'(opcode_o) + int'(bank_o), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 first cycle cmd", int'(cmd_o), 0);

    // R2 sweep, clock enable high; R9 bad stop after auto-precharge read
    for (int i = 0; i < 16; i++) begin
      drive(4'(i), 1'b1, 2'd0, 13'h0400, 2'd0);
      chk($sformatf("R2 R7 class %0d", i), int'(cmd_o), cls(4'(i), 1'b1));
      cause($sformatf("R9 sweep cause %0d", i), (i == 6) ? 2 : 0);
    end
    // R8 sweep, clock enable low
    for (int i = 0; i < 16; i++) begin
      if (i == 1) continue;
      drive(4'(i), 1'b0, 2'd0, 13'h0400, 2'd0);
      chk($sformatf("R8 class %0d", i), int'(cmd_o), cls(4'(i), 1'b0));
      cause($sformatf("R8 cause %0d", i), (i >= 8 || i == 7) ? 0 : 1);
    end
    nop(5);

    // R3 R4 R5 R6 field sweep
    for (int b = 0; b < 4; b++) begin
      for (int j = 0; j < 6; j++) begin
        logic [12:0] a;
        a = av[j];
        drive(E_ACT, 1'b1, 2'(b), a, 2'd0);
        chk("R4 act bank", int'(bank_o), b);
        chk("R4 act row", int'(row_o), int'(a));
        cause("R4 act", 0);
        drive(E_RD, 1'b1, 2'(b), a, 2'd0);
        chk("R3 rd cmd", int'(cmd_o), 2);
        chk("R3 rd bank", int'(bank_o), b);
        chk("R3 rd col", int'(col_o), int'(a[9:0]));
        chk("R3 rd ap", int'(ap_o), int'(a[10]));
        chk("R4 rd row", int'(row_o), 0);
        drive(E_WR, 1'b1, 2'(b), a, 2'd0);
        chk("R3 wr cmd", int'(cmd_o), 3);
        chk("R3 wr col", int'(col_o), int'(a[9:0]));
        chk("R3 wr ap", int'(ap_o), int'(a[10]));
        drive(E_PRE, 1'b1, 2'(b), a, 2'd0);
        chk("R5 all", int'(all_bank_o), int'(a[10]));
        chk("R5 bank", int'(bank_o), a[10] ? 0 : b);
        drive(E_LMR, 1'b1, 2'(b), a, 2'd0);
        chk("R6 ext", int'(ext_mr_o), (b == 2) ? 1 : 0);
        chk("R6 opcode", int'(opcode_o), int'(a));
        cause("R6 select", (b == 1 || b == 3) ? 4 : 0);
      end
    end
    nop(5);

    // R6 R11 burst of 4 cycles with mask lanes
    drive(E_LMR, 1'b1, 2'd0, 13'd3, 2'd0);
    cause("R6 load bl", 0);
    drive(E_WR, 1'b1, 2'd1, 13'h0012, 2'd0);
    chk("R11 beat on write cycle", int'(wbeat_o), 0);
    beats("R11 R10 write", 4);

    // R9 legal stop ends a plain read
    drive(E_RD, 1'b1, 2'd2, 13'h0010, 2'd0);
    nop(1);
    drive(E_BST, 1'b1, 2'd0, 13'd0, 2'd0);
    chk("R9 stop cmd", int'(cmd_o), 4);
    cause("R9 legal stop", 0);
    drive(E_BST, 1'b1, 2'd0, 13'd0, 2'd0);
    cause("R9 stop after stop", 2);

    // R10 burst window edges
    drive(E_RD, 1'b1, 2'd2, 13'h0010, 2'd0);
    nop(3);
    drive(E_BST, 1'b1, 2'd0, 13'd0, 2'd0);
    cause("R10 stop on last cycle", 0);
    drive(E_RD, 1'b1, 2'd2, 13'h0010, 2'd0);
    nop(4);
    drive(E_BST, 1'b1, 2'd0, 13'd0, 2'd0);
    cause("R10 stop after expiry", 2);

    // R9 R11 stop during a write: error and beat together
    drive(E_WR, 1'b1, 2'd0, 13'h0020, 2'd0);
    drive(E_BST, 1'b1, 2'd0, 13'd0, 2'd2);
    chk("R9 stop in write cmd", int'(cmd_o), 4);
    cause("R9 stop in write", 2);
    chk("R11 beat with stop", int'(wbeat_o), 1);
    chk("R11 mask with stop", int'(wmask_o), 2);
    drive(E_NOP, 1'b1, 2'd0, 13'd0, 2'd1);
    chk("R9 write continues", int'(wbeat_o), 1);
    nop(4);

    // R10 precharge effects
    drive(E_RD, 1'b1, 2'd3, 13'h0000, 2'd0);
    drive(E_PRE, 1'b1, 2'd1, 13'h0000, 2'd0);
    chk("R5 pre bank", int'(bank_o), 1);
    drive(E_BST, 1'b1, 2'd0, 13'd0, 2'd0);
    cause("R10 other bank keeps burst", 0);
    drive(E_RD, 1'b1, 2'd3, 13'h0000, 2'd0);
    drive(E_PRE, 1'b1, 2'd3, 13'h0000, 2'd0);
    drive(E_BST, 1'b1, 2'd0, 13'd0, 2'd0);
    cause("R10 same bank ends burst", 2);
    drive(E_RD, 1'b1, 2'd3, 13'h0000, 2'd0);
    drive(E_PRE, 1'b1, 2'd1, 13'h0400, 2'd0);
    drive(E_BST, 1'b1, 2'd0, 13'd0, 2'd0);
    cause("R10 all banks ends burst", 2);

    // R9 read with auto precharge
    drive(E_RD, 1'b1, 2'd0, 13'h0400, 2'd0);
    drive(E_BST, 1'b1, 2'd0, 13'd0, 2'd0);
    cause("R9 stop after ap read", 2);
    nop(5);

    // R6 only base-register loads change the burst
    drive(E_LMR, 1'b1, 2'd1, 13'd1, 2'd0);
    cause("R6 sel 01", 4);
    drive(E_LMR, 1'b1, 2'd3, 13'd1, 2'd0);
    cause("R6 sel 11", 4);
    drive(E_LMR, 1'b1, 2'd2, 13'd1, 2'd0);
    chk("R6 ext set", int'(ext_mr_o), 1);
    cause("R6 ext ok", 0);
    drive(E_WR, 1'b1, 2'd0, 13'd0, 2'd0);
    beats("R6 burst unchanged", 4);
    drive(E_LMR, 1'b1, 2'd0, 13'd1, 2'd0);
    drive(E_WR, 1'b1, 2'd0, 13'd0, 2'd0);
    beats("R6 burst of one", 1);

    // R7 refresh and self refresh
    drive(E_REF, 1'b1, 2'd0, 13'd0, 2'd0);
    chk("R7 auto refresh", int'(cmd_o), 6);
    drive(E_REF, 1'b0, 2'd0, 13'd0, 2'd0);
    chk("R7 sref entry", int'(cmd_o), 7);
    cause("R7 sref entry", 0);
    drive(E_ACT, 1'b0, 2'd1, 13'd7, 2'd0);
    chk("R7 inside sref", int'(cmd_o), 0);
    cause("R7 inside sref", 0);
    drive(E_WR, 1'b0, 2'd1, 13'd7, 2'd0);
    chk("R7 inside sref wr", int'(cmd_o), 0);
    drive(E_RD, 1'b1, 2'd1, 13'd7, 2'd0);
    chk("R7 exit cycle", int'(cmd_o), 0);
    drive(E_ACT, 1'b1, 2'd1, 13'd5, 2'd0);
    chk("R7 after exit", int'(cmd_o), 1);
    chk("R7 after exit row", int'(row_o), 5);
    drive(E_BST, 1'b1, 2'd0, 13'd0, 2'd0);
    cause("R7 exit read had no effect", 2);
    chk("R7 no write beat from sref", int'(wbeat_o), 0);

    // R8 low clock enable commands change nothing
    drive(E_WR, 1'b0, 2'd0, 13'd0, 2'd0);
    chk("R8 low cke write cmd", int'(cmd_o), 3);
    cause("R8 low cke write", 1);
    drive(E_NOP, 1'b1, 2'd0, 13'd0, 2'd3);
    chk("R8 no burst started", int'(wbeat_o), 0);
    drive(E_LMR, 1'b0, 2'd0, 13'd3, 2'd0);
    cause("R8 low cke load", 1);
    drive(E_WR, 1'b1, 2'd0, 13'd0, 2'd0);
    beats("R8 burst length kept", 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule